// File: doc/BRIEF.md
# ADC Calibration Sequencer

This controller runs the digital side of a 10-bit two-step converter's self-calibration. It watches three asynchronous control inputs. A calibration reset input (`cal_reset_i`) and an active-low chip enable (`chip_en_n_i`) launch a long startup calibration. A calibration pulse input (`cal_pulse_i`) requests a short periodic recalibration. Each input passes through a two-stage synchroniser and an edge register. The startup run is timed by a down-counter. The periodic run is handled by a small state machine that reserves the comparator array for a fixed number of clocks, after a fixed delay.

The block sits between the converter core and the output register. It passes the raw conversion word to `data_o` with one clock of latency. It clears `data_valid_o` whenever the word cannot be trusted, and it freezes `data_o` on its previous value while the comparators are borrowed. `upper_only_o` stays high until one startup calibration has run to completion, because until then only the five most significant bits of a word can be trusted. Chip standby (`chip_en_n_i` high) freezes the output and pauses the periodic scheduler.

Periodic state machine: `PC_IDLE` goes to `PC_WAIT` on an accepted trigger. `PC_WAIT` goes to `PC_FREEZE` when its delay timer reaches zero. `PC_FREEZE` returns to `PC_IDLE` when its length timer reaches zero. All three states hold while in standby.

Top module: `adc_cal_sequencer`

## Requirements
- R1: Outside standby, startup calibration and freeze, `data_o` equals the `raw_word_i` sampled at the previous rising clock edge, and `data_valid_o` is 1.
- R2: A rising edge on `cal_reset_i` starts startup calibration. `calibrating_o` goes high after the third rising clock edge that follows the input change.
- R3: A falling edge on `chip_en_n_i` starts startup calibration with the same latency. `calibrating_o` then stays high for exactly STARTUP_CYCLES clocks.
- R4: `data_valid_o` is 0 in every cycle in which `calibrating_o` is 1, and in the first cycle after it falls.
- R5: A falling edge on `cal_pulse_i` that is detected at clock edge D makes `cal_busy_o` high for exactly FREEZE_LEN (4) cycles. These are the cycles that end at edges D+FREEZE_DELAY to D+FREEZE_DELAY+FREEZE_LEN-1, with FREEZE_DELAY = 7.
- R6: At those four edges `data_o` does not load. It repeats the word it held before them, and `data_valid_o` is 0 after each of them.
- R7: A falling edge on `cal_pulse_i` is ignored while startup calibration is running: `cal_busy_o` stays 0.
- R8: A new start edge during startup calibration reloads the counter. `calibrating_o` then falls STARTUP_CYCLES clocks after the new detection.
- R9: While the synchronised `chip_en_n_i` is 1, `data_o` holds, `data_valid_o` is 0, and the periodic delay and length timers do not advance.
- R10: `upper_only_o` is 1 from reset until the first startup calibration completes, then stays 0.
- R11: While `sys_rst_n` is 0: `data_o` = 0, `data_valid_o` = 0, `calibrating_o` = 0, `cal_busy_o` = 0, and `upper_only_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| sys_rst_n | input | 1 | Active-low power-on reset of the controller flops |
| cal_reset_i | input | 1 | Asynchronous calibration reset; its rising edge starts startup calibration |
| chip_en_n_i | input | 1 | Asynchronous chip enable, low = active, high = standby; its falling edge starts startup calibration |
| cal_pulse_i | input | 1 | Asynchronous calibration pulse; its falling edge requests a periodic run |
| raw_word_i | input | 10 | Raw conversion word from the core |
| data_o | output | 10 | Registered, held output word |
| data_valid_o | output | 1 | Output word is a fresh, usable sample |
| calibrating_o | output | 1 | Startup calibration is running |
| cal_busy_o | output | 1 | Comparator array is reserved for periodic calibration |
| upper_only_o | output | 1 | Only the upper five bits are trustworthy (no completed startup calibration yet) |

## Verification
The bench sets STARTUP_CYCLES to 40 and keeps CNT_W at 16, with FREEZE_DELAY at 7 and FREEZE_LEN at 4. A short startup run makes these cases reachable within a few hundred clocks: the exact end of a startup run, a restart in the middle of a run, and the clearing of `upper_only_o`. The default freeze timing keeps the exact seven-clock delay and four-clock hold under test. A standby inserted between trigger and freeze checks that the pause shifts the freeze window by the standby length.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
    typedef enum logic [1:0] {
        PC_IDLE   = 2'd0,
        PC_WAIT   = 2'd1,
        PC_FREEZE = 2'd2
    } pcal_state_e;
endpackage

// File: rtl/adc_cal_edge.sv
// Two-flop synchroniser plus edge register for one asynchronous control.
module adc_cal_edge #(
    parameter logic RST_VAL     = 1'b0,
    parameter bit   DETECT_RISE = 1'b1
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic edge_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl_o = sync_q;

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_o = sync_q & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~sync_q & prev_q;
        end
    endgenerate
endmodule

// File: rtl/adc_cal_startup.sv
// Startup calibration interval counter with sticky completion flag.
module adc_cal_startup #(
    parameter int STARTUP_CYCLES = 33000,
    parameter int CNT_W          = 16
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic start_i,
    output logic active_o,
    output logic done_o
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STARTUP_CYCLES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (start_i) begin
                cnt_q <= LOAD_VAL;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - ONE;
            end
            if (!start_i && cnt_q == ONE) begin
                done_q <= 1'b1;
            end
        end
    end

    assign active_o = (cnt_q != '0);
    assign done_o   = done_q;
endmodule

// File: rtl/adc_cal_periodic.sv
// Periodic recalibration scheduler: delay, then comparator reservation.
module adc_cal_periodic
    import adc_cal_pkg::*;
#(
    parameter int FREEZE_DELAY = 7,
    parameter int FREEZE_LEN   = 4
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic trig_i,
    input  logic pause_i,
    output logic busy_o,
    output logic idle_o
);
    localparam int TW = $clog2(FREEZE_DELAY + FREEZE_LEN) + 1;
    localparam logic [TW-1:0] DELAY_LOAD = TW'(FREEZE_DELAY - 2);
    localparam logic [TW-1:0] LEN_LOAD   = TW'(FREEZE_LEN - 1);
    localparam logic [TW-1:0] T_ONE      = TW'(1);

    pcal_state_e state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        if (!pause_i) begin
            unique case (state_q)
                PC_IDLE: begin
                    if (trig_i) begin
                        state_d = PC_WAIT;
                        tmr_d   = DELAY_LOAD;
                    end
                end
                PC_WAIT: begin
                    if (tmr_q == '0) begin
                        state_d = PC_FREEZE;
                        tmr_d   = LEN_LOAD;
                    end else begin
                        tmr_d = tmr_q - T_ONE;
                    end
                end
                PC_FREEZE: begin
                    if (tmr_q == '0) begin
                        state_d = PC_IDLE;
                    end else begin
                        tmr_d = tmr_q - T_ONE;
                    end
                end
                default: begin
                    state_d = PC_IDLE;
                    tmr_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            state_q <= PC_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        busy_o = (state_q == PC_FREEZE);
        idle_o = (state_q == PC_IDLE);
    end
endmodule

// File: rtl/adc_cal_sequencer.sv
// Top: calibration sequencing and output hold for the converter core.
module adc_cal_sequencer #(
    parameter int DATA_W         = 10,
    parameter int STARTUP_CYCLES = 33000,
    parameter int CNT_W          = 16,
    parameter int FREEZE_DELAY   = 7,
    parameter int FREEZE_LEN     = 4
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              cal_reset_i,
    input  logic              chip_en_n_i,
    input  logic              cal_pulse_i,
    input  logic [DATA_W-1:0] raw_word_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_valid_o,
    output logic              calibrating_o,
    output logic              cal_busy_o,
    output logic              upper_only_o
);
    logic rst_rise, rst_lvl_unused;
    logic ce_fall, ce_standby;
    logic cal_fall, cal_lvl_unused;
    logic su_active, su_done, su_busy;
    logic pc_busy, pc_idle_unused;
    logic pc_trig, load_en, valid_d;

    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    adc_cal_edge #(.RST_VAL(1'b0), .DETECT_RISE(1'b1)) u_rst_edge (
        .clk(clk), .sys_rst_n(sys_rst_n), .async_i(cal_reset_i),
        .lvl_o(rst_lvl_unused), .edge_o(rst_rise)
    );

    adc_cal_edge #(.RST_VAL(1'b1), .DETECT_RISE(1'b0)) u_ce_edge (
        .clk(clk), .sys_rst_n(sys_rst_n), .async_i(chip_en_n_i),
        .lvl_o(ce_standby), .edge_o(ce_fall)
    );

    adc_cal_edge #(.RST_VAL(1'b1), .DETECT_RISE(1'b0)) u_cal_edge (
        .clk(clk), .sys_rst_n(sys_rst_n), .async_i(cal_pulse_i),
        .lvl_o(cal_lvl_unused), .edge_o(cal_fall)
    );

    adc_cal_startup #(.STARTUP_CYCLES(STARTUP_CYCLES), .CNT_W(CNT_W)) u_startup (
        .clk(clk), .sys_rst_n(sys_rst_n), .start_i(rst_rise | ce_fall),
        .active_o(su_active), .done_o(su_done)
    );

    assign su_busy = su_active | rst_rise | ce_fall;
    assign pc_trig = cal_fall & ~su_busy & ~ce_standby;

    adc_cal_periodic #(.FREEZE_DELAY(FREEZE_DELAY), .FREEZE_LEN(FREEZE_LEN)) u_periodic (
        .clk(clk), .sys_rst_n(sys_rst_n), .trig_i(pc_trig), .pause_i(ce_standby),
        .busy_o(pc_busy), .idle_o(pc_idle_unused)
    );

    assign load_en = ~ce_standby & ~pc_busy;
    assign valid_d = load_en & ~su_busy;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (load_en) begin
                data_q <= raw_word_i;
            end
            valid_q <= valid_d;
        end
    end

    assign data_o        = data_q;
    assign data_valid_o  = valid_q;
    assign calibrating_o = su_active;
    assign cal_busy_o    = pc_busy;
    assign upper_only_o  = ~su_done;
endmodule

// File: rtl/adc_cal_checker.sv
module adc_cal_checker #(
    parameter int DATA_W     = 10,
    parameter int FREEZE_LEN = 4
) (
    input logic              clk,
    input logic              sys_rst_n,
    input logic              chip_en_n_i,
    input logic [DATA_W-1:0] data_o,
    input logic              data_valid_o,
    input logic              calibrating_o,
    input logic              cal_busy_o,
    input logic              upper_only_o
);
    logic [7:0] busy_run;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) busy_run <= '0;
        else if (cal_busy_o) busy_run <= busy_run + 8'd1;
        else busy_run <= '0;
    end

    AST_CAL_NO_VALID: assert property (@(posedge clk) disable iff (!sys_rst_n)
        calibrating_o |-> !data_valid_o); // R4

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!sys_rst_n)
        cal_busy_o |-> (busy_run < 8'(FREEZE_LEN))); // R5

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!sys_rst_n)
        cal_busy_o |=> ($stable(data_o) && !data_valid_o)); // R6

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $past(chip_en_n_i, 3) |-> !data_valid_o); // R9

    AST_UPPER_STICKY: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !upper_only_o |=> !upper_only_o); // R10

    AST_END_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $fell(calibrating_o) |-> !upper_only_o); // R10
endmodule

bind adc_cal_sequencer adc_cal_checker #(.DATA_W(DATA_W), .FREEZE_LEN(FREEZE_LEN)) u_chk (
    .clk(clk), .sys_rst_n(sys_rst_n), .chip_en_n_i(chip_en_n_i),
    .data_o(data_o), .data_valid_o(data_valid_o), .calibrating_o(calibrating_o),
    .cal_busy_o(cal_busy_o), .upper_only_o(upper_only_o)
);

// File: tb/sim_adc_cal_sequencer.sv
`timescale 1ns/1ps
module sim_adc_cal_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 40;
    localparam int DW = 10;

    localparam logic [2*DW-1:0] VEC [8] = '{
        {10'h3FF, 10'h3FF}, {10'h000, 10'h000}, {10'h200, 10'h200}, {10'h1FF, 10'h1FF},
        {10'h155, 10'h155}, {10'h2AA, 10'h2AA}, {10'h001, 10'h001}, {10'h3FE, 10'h3FE}
    };

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic cal_reset_i = 1'b0, chip_en_n_i = 1'b1, cal_pulse_i = 1'b1;
    logic [DW-1:0] raw_word_i = '0;
    logic [DW-1:0] data_o;
    logic data_valid_o, calibrating_o, cal_busy_o, upper_only_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_cal_sequencer #(.DATA_W(DW), .STARTUP_CYCLES(N), .CNT_W(16),
                        .FREEZE_DELAY(7), .FREEZE_LEN(4)) u0 (
        .clk(clk), .sys_rst_n(sys_rst_n), .cal_reset_i(cal_reset_i),
        .chip_en_n_i(chip_en_n_i), .cal_pulse_i(cal_pulse_i), .raw_word_i(raw_word_i),
        .data_o(data_o), .data_valid_o(data_valid_o), .calibrating_o(calibrating_o),
        .cal_busy_o(cal_busy_o), .upper_only_o(upper_only_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] base;
        int exp_d;
        @(negedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11 data", int'(data_o), 0);
        check("R11 valid", int'(data_valid_o), 0);
        check("R11 calibrating", int'(calibrating_o), 0);
        check("R11 busy", int'(cal_busy_o), 0);
        check("R11 upper_only", int'(upper_only_o), 1);
        sys_rst_n = 1'b1;
        tick(); tick(); tick();
        check("R9 standby valid", int'(data_valid_o), 0);

        // R3 startup via CE fall
        chip_en_n_i = 1'b0;
        for (int j = 1; j <= N + 4; j++) begin
            tick();
            if (j == 2) check("R3 not yet", int'(calibrating_o), 0);
            if (j == 3) check("R3 starts", int'(calibrating_o), 1);
            if (j == N + 2) check("R3 last cycle", int'(calibrating_o), 1);
            if (j == N + 3) check("R3 ended", int'(calibrating_o), 0);
            if (j == N + 2) check("R10 before done", int'(upper_only_o), 1);
            if (j == N + 3) check("R10 after done", int'(upper_only_o), 0);
            if (j >= 3 && j <= N + 3) check("R4 valid low", int'(data_valid_o), 0);
            if (j == N + 4) check("R4 valid back", int'(data_valid_o), 1);
        end

        // R1 vector table
        foreach (VEC[i]) begin
            raw_word_i = VEC[i][2*DW-1:DW];
            tick();
            check("R1 data", int'(data_o), int'(VEC[i][DW-1:0]));
            check("R1 valid", int'(data_valid_o), 1);
        end

        // R5 R6 periodic freeze
        base = 10'h100;
        for (int j = 1; j <= 16; j++) begin
            raw_word_i = base + DW'(j);
            if (j == 1) cal_pulse_i = 1'b0;
            if (j == 4) cal_pulse_i = 1'b1;
            tick();
            exp_d = (j >= 10 && j <= 13) ? int'(base) + 9 : int'(base) + j;
            check("R6 data", int'(data_o), exp_d);
            check("R6 valid", int'(data_valid_o), (j >= 10 && j <= 13) ? 0 : 1);
            check("R5 busy", int'(cal_busy_o), (j >= 9 && j <= 12) ? 1 : 0);
        end

        // R2 R7 R8 startup via RESET rise, CAL ignored, restart reloads
        for (int j = 1; j <= N + 20; j++) begin
            if (j == 1) cal_reset_i = 1'b1;
            if (j == 6) cal_pulse_i = 1'b0;
            if (j == 9) cal_pulse_i = 1'b1;
            if (j == 15) cal_reset_i = 1'b0;
            if (j == 17) cal_reset_i = 1'b1;
            tick();
            if (j == 2) check("R2 not yet", int'(calibrating_o), 0);
            if (j == 3) check("R2 starts", int'(calibrating_o), 1);
            if (cal_busy_o) check("R7 busy during startup", 1, 0);
            if (j == N + 3) check("R8 still running", int'(calibrating_o), 1);
            if (j == N + 18) check("R8 reload last", int'(calibrating_o), 1);
            if (j == N + 19) check("R8 reload end", int'(calibrating_o), 0);
        end
        check("R7 no busy", int'(cal_busy_o), 0);
        cal_reset_i = 1'b0;
        tick(); tick(); tick();

        // R9 standby pauses periodic timers and holds output
        base = 10'h080;
        for (int j = 1; j <= 24; j++) begin
            raw_word_i = base + DW'(j);
            if (j == 1) cal_pulse_i = 1'b0;
            if (j == 4) begin cal_pulse_i = 1'b1; chip_en_n_i = 1'b1; end
            if (j == 14) chip_en_n_i = 1'b0;
            tick();
            if (j <= 5) exp_d = int'(base) + j;
            else if (j <= 15) exp_d = int'(base) + 5;
            else if (j <= 19) exp_d = int'(base) + j;
            else if (j <= 23) exp_d = int'(base) + 19;
            else exp_d = int'(base) + 24;
            check("R9 data", int'(data_o), exp_d);
            check("R9 busy", int'(cal_busy_o), (j >= 19 && j <= 22) ? 1 : 0);
            if (j == 5) check("R9 valid before", int'(data_valid_o), 1);
            if (j >= 6 && j <= 15) check("R9 valid standby", int'(data_valid_o), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule